// File: doc/BRIEF.md
# Carry-Scheduled Carry Select Adder

This block is a purely combinational adder of parameterised width. It adds two unsigned operands and a carry input, and returns the sum together with a carry output. Its structure differs from a classic carry select adder. No sum is ever formed twice. Instead, the block builds two complete carry words: one that assumes the carry input is low, and one that assumes it is high. It picks the real carry word with a single AND-OR gate per bit. Only after that choice does it form the sum, with one XOR per bit.

The operands first pass through a bitwise stage that produces a propagate word (XOR) and a generate word (AND). Two ripple carry chains consume these words. The first chain is seeded as if the carry input were 0, and the second as if it were 1. For any given inputs, every bit set in the first carry word is also set in the second. Because of this nesting, the merge stage reduces to an OR of the low-assumption word with the high-assumption word gated by the carry input. The final stage XORs the propagate word with the merged carries, shifted up by one place, and places the carry input at bit 0. The top bit of the merged carry word becomes the carry output.

The block is meant to sit in a datapath wherever a wide add with carry input is needed, for example in the accumulate step of a multiply-accumulate unit.

Top module: `cs_adder`

## Requirements
- R1: For every operand pair and carry input, the concatenation {cout, sum} equals the unsigned value a + b + cin.
- R2: When a and b share no set bit and cin is 0, sum equals a OR b and cout is 0.
- R3: With cin at 0, the result equals a + b, taken from the carry word built for a carry input of 0.
- R4: With cin at 1, the merged carry word equals the carry word built for a carry input of 1. All-ones plus zero plus a carry input of 1 gives a sum of 0 and a cout of 1.
- R5: At every bit position, a set bit in the carry-in-0 word implies a set bit in the carry-in-1 word.
- R6: cout is the most significant bit of the merged carry word. Adding two all-ones operands with cin at 1 gives an all-ones sum and a cout of 1.
- R7: Sum bit 0 equals a[0] XOR b[0] XOR cin.
- R8: The width parameter W (at least 2) sets the operand and sum widths. The behaviour in R1 holds at every width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| cin | input | 1 | Carry input |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry output, bit W of a + b + cin |

## Verification
The bench builds two copies of the adder. One is at the default width of 32, and one is at a width of 6. At width 6, all 8192 combinations of a, b and cin can be applied. This covers every carry chain length, and every case where the two carry words agree or differ. At width 32, directed corner values and random operands reach full-length propagation from bit 0 to cout. They also cover the disjoint-operand case and the nesting of the two carry words across a realistic datapath width.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Which constant carry input a carry chain is built for
    typedef enum logic {
        SEED_ZERO = 1'b0,
        SEED_ONE  = 1'b1
    } seed_e;

endpackage

// File: rtl/csa_half_sum.sv
module csa_half_sum #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign prop[i] = op_a[i] ^ op_b[i];
            assign gen[i]  = op_a[i] & op_b[i];
        end
    endgenerate

endmodule

// File: rtl/csa_carry_chain.sv
module csa_carry_chain
    import csa_pkg::*;
#(
    parameter int    W    = 32,
    parameter seed_e SEED = SEED_ZERO
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    output logic [W-1:0] carry
);

    logic bit0;

    // The fixed seed simplifies bit 0 differently for each chain
    generate
        if (SEED == SEED_ONE) begin : g_seed_one
            assign bit0 = gen[0] | prop[0];
        end else begin : g_seed_zero
            assign bit0 = gen[0];
        end
    endgenerate

    always_comb begin
        logic run;
        run      = bit0;
        carry[0] = bit0;
        for (int i = 1; i < W; i++) begin
            run      = (run & prop[i]) | gen[i];
            carry[i] = run;
        end
    end

endmodule

// File: rtl/csa_carry_merge.sv
module csa_carry_merge #(
    parameter int W = 32
) (
    input  logic [W-1:0] carry_lo,
    input  logic [W-1:0] carry_hi,
    input  logic         sel,
    output logic [W-1:0] carry
);

    // Nesting of carry_lo inside carry_hi lets one AND-OR replace a mux
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign carry[i] = carry_lo[i] | (sel & carry_hi[i]);
        end
    endgenerate

endmodule

// File: rtl/csa_final_sum.sv
module csa_final_sum #(
    parameter int W = 32
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] carry,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    assign sum  = prop ^ {carry[W-2:0], cin};
    assign cout = carry[W-1];

endmodule

// File: rtl/cs_adder.sv
module cs_adder
    import csa_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] c_lo;
    logic [W-1:0] c_hi;
    logic [W-1:0] c_fin;

    csa_half_sum #(.W(W)) u_half (
        .op_a (a),
        .op_b (b),
        .prop (prop),
        .gen  (gen)
    );

    csa_carry_chain #(.W(W), .SEED(SEED_ZERO)) u_chain_lo (
        .prop  (prop),
        .gen   (gen),
        .carry (c_lo)
    );

    csa_carry_chain #(.W(W), .SEED(SEED_ONE)) u_chain_hi (
        .prop  (prop),
        .gen   (gen),
        .carry (c_hi)
    );

    csa_carry_merge #(.W(W)) u_merge (
        .carry_lo (c_lo),
        .carry_hi (c_hi),
        .sel      (cin),
        .carry    (c_fin)
    );

    csa_final_sum #(.W(W)) u_fsum (
        .prop  (prop),
        .carry (c_fin),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

endmodule

// File: rtl/cs_adder_chk.sv
module cs_adder_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout,
    input logic [W-1:0] c_lo,
    input logic [W-1:0] c_hi,
    input logic [W-1:0] c_fin
);

    logic [W:0] ref_total;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    always_comb begin
        AST_SUM_TOTAL: assert ({cout, sum} == ref_total) else $error("total mismatch"); // R1
        AST_DISJOINT_OR: assert (!(((a & b) == '0) && !cin) || ((sum == (a | b)) && !cout)) else $error("disjoint add"); // R2
        AST_LO_WORD_USED: assert (cin || (c_fin == c_lo)) else $error("cin=0 carry word"); // R3
        AST_HI_WORD_USED: assert (!cin || (c_fin == c_hi)) else $error("cin=1 carry word"); // R4
        AST_CARRY_NEST: assert ((c_lo & ~c_hi) == '0) else $error("carry nesting"); // R5
        AST_SUM_LSB: assert (sum[0] == (a[0] ^ b[0] ^ cin)) else $error("lsb"); // R7
    end

endmodule

bind cs_adder cs_adder_chk #(.W(W)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .c_lo  (c_lo),
    .c_hi  (c_hi),
    .c_fin (c_fin)
);

// File: tb/tb_cs_adder.sv
module tb_cs_adder;

    localparam int WB = 32;
    localparam int WS = 6;

    typedef struct {
        logic [WB:0] exp;
        string       tag;
    } item_b_t;

    typedef struct {
        logic [WS:0] exp;
        string       tag;
    } item_s_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [WB-1:0] a_b, b_b, sum_b;
    logic          cin_b, cout_b;
    logic [WS-1:0] a_s, b_s, sum_s;
    logic          cin_s, cout_s;

    cs_adder #(.W(WB)) dut (
        .a(a_b), .b(b_b), .cin(cin_b), .sum(sum_b), .cout(cout_b)
    );

    cs_adder #(.W(WS)) dut6 (
        .a(a_s), .b(b_s), .cin(cin_s), .sum(sum_s), .cout(cout_s)
    );

    item_b_t q_b[$];
    item_s_t q_s[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Driver: apply one vector to each copy per cycle, queue expected result
    task automatic drive(input logic [WB-1:0] x, input logic [WB-1:0] y, input logic c,
                         input string tb, input logic [WS-1:0] xs, input logic [WS-1:0] ys,
                         input logic cs, input string ts);
        item_b_t ib;
        item_s_t is;
        @(posedge clk);
        a_b = x; b_b = y; cin_b = c;
        a_s = xs; b_s = ys; cin_s = cs;
        ib.exp = {1'b0, x} + {1'b0, y} + {{WB{1'b0}}, c};
        ib.tag = tb;
        is.exp = {1'b0, xs} + {1'b0, ys} + {{WS{1'b0}}, cs};
        is.tag = ts;
        q_b.push_back(ib);
        q_s.push_back(is);
    endtask

    // Monitor: compare at the falling edge after each drive
    always @(negedge clk) begin
        if (rst_n && q_b.size() > 0) begin
            item_b_t ib;
            item_s_t is;
            ib = q_b.pop_front();
            is = q_s.pop_front();
            checks += 2;
            if ({cout_b, sum_b} !== ib.exp) begin
                errors++;
                $display("FAIL %s W32 got %h exp %h", ib.tag, {cout_b, sum_b}, ib.exp);
            end
            if ({cout_s, sum_s} !== is.exp) begin
                errors++;
                $display("FAIL %s W6 got %h exp %h", is.tag, {cout_s, sum_s}, is.exp);
            end
        end
    end

    initial begin
        a_b = '0; b_b = '0; cin_b = 1'b0;
        a_s = '0; b_s = '0; cin_s = 1'b0;
        repeat (3) @(negedge clk);
        // Reset state: zero inputs give zero result (R1)
        checks++;
        if ({cout_b, sum_b} !== '0) begin
            errors++;
            $display("FAIL R1 reset got %h exp 0", {cout_b, sum_b});
        end
        rst_n = 1'b1;

        // Directed corners at width 32, width 6 mirrors them
        drive(32'hA5A5_0000, 32'h0000_5A5A, 1'b0, "R2 disjoint",
              6'b101000, 6'b000101, 1'b0, "R2 disjoint");
        drive(32'h1234_5678, 32'h0FED_CBA9, 1'b0, "R3 cin0",
              6'd27, 6'd19, 1'b0, "R3 cin0");
        drive(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4 ones plus cin",
              6'h3F, 6'h00, 1'b1, "R4 ones plus cin");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 alternating",
              6'b101010, 6'b010101, 1'b1, "R4 alternating");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6 max",
              6'h3F, 6'h3F, 1'b1, "R6 max");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R6 msb carry",
              6'h20, 6'h20, 1'b0, "R6 msb carry");
        drive(32'h0000_0001, 32'h0000_0000, 1'b1, "R7 lsb",
              6'd1, 6'd0, 1'b1, "R7 lsb");
        drive(32'h0000_0000, 32'h0000_0000, 1'b1, "R7 cin only",
              6'd0, 6'd0, 1'b1, "R7 cin only");

        // Exhaustive at width 6, random at width 32
        for (int k = 0; k < (1 << (2 * WS + 1)); k++) begin
            logic [2*WS:0] v;
            v = k[2*WS:0];
            drive($urandom(), $urandom(), 1'($urandom()), "R1 random",
                  v[WS-1:0], v[2*WS-1:WS], v[2*WS], "R8 R5 exhaustive");
        end

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule